// File: doc/BRIEF.md
# GPIO Wake and SMI Event Controller

This block watches a bank of general-purpose pins, organised in groups of eight, and turns chosen pin transitions into sticky status bits. Each pin feeds two independent status paths. One drives a power-management wake request and the other a system-management interrupt. Each pin has a polarity bit that picks the rising or the falling edge. An either-edge select makes a pin fire on both transitions, and it also records those transitions in a dedicated miscellaneous status register.

Software reaches the block through a byte-wide register port. The same port carries per-pin direction and data control. Input pins return their synchronised level on a data read and ignore data writes. Output pins store the written value, drive it out and read it back. Status bits are cleared by writing 1. An edge that lands in the same cycle as a clear still leaves the bit set.

Top module: `gpio_event_ctrl`

## Requirements
- R1: After reset, every status, enable, direction, data, polarity and either-edge bit reads 0, the global wake enable is 0, and both event outputs are low.
- R2: With polarity 0 (the reset value), a low-to-high transition on a pin sets that pin's wake status bit and its SMI status bit. The set is visible on a read three clock edges after the pin changes.
- R3: With polarity 1, only a high-to-low transition sets the status bits, and a low-to-high transition leaves them unchanged.
- R4: Status bits are sticky. Writing 1 to a bit position clears it and writing 0 leaves it as it is. An edge in the same cycle as a clear write keeps the bit at 1.
- R5: The wake output is a registered level that is high exactly when the global wake enable is 1 and some wake status bit has its wake enable bit at 1. It follows these inputs by one clock.
- R6: The SMI output is a registered level that is high exactly when some SMI status bit has its SMI enable bit at 1, and it does not depend on the global wake enable.
- R7: A pin with its either-edge bit at 1 sets its wake, SMI and miscellaneous status bits on both transitions. A miscellaneous status bit is never set for a pin whose either-edge bit is 0.
- R8: For a pin with direction 0 (input), a data read returns the synchronised pin level. A data write leaves the stored output value and the pin output unchanged.
- R9: For a pin with direction 1 (output), a data write stores the bit, drives it on the pin output with output enable high, and a data read returns it.
- R10: The register address is {group, select}, with the 4-bit select in the low bits: 0 polarity, 1 direction, 2 data, 3 wake status, 4 wake enable, 5 SMI status, 6 SMI enable, 7 either-edge, 8 miscellaneous status, 9 global wake enable (bit 0, any group). Bit i of a group register belongs to pin group*8+i.
- R11: Each group's registers affect only that group's eight pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | N | Pin levels from the pads (asynchronous) |
| pin_out | output | N | Stored output data per pin |
| pin_oe | output | N | Output enable per pin (direction bit) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | GW+4 | Register address {group, select} |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from address) |
| pme_out | output | 1 | Wake event request, active high |
| smi_out | output | 1 | System-management interrupt, active high |

## Verification
A status bit stuck or lost inside the block shows up on a status read three edges after the pin change that should have set it. It also shows up on the event outputs one edge after that, whenever the matching enable is on. A bad polarity or either-edge decode appears as a status bit that sets on the wrong transition. A clear that wins over a coincident edge shows as a 0 read right after the race. The bench models every pin's edge history and compares all status registers and both outputs after each random step.

// File: rtl/gpio_evt_pkg.sv
// Shared definitions for the GPIO event controller.
// Assumes pins are grouped eight per register.
package gpio_evt_pkg;
    localparam int GRP_PINS = 8;

    typedef enum logic [3:0] {
        SEL_POL  = 4'd0,
        SEL_DIR  = 4'd1,
        SEL_DATA = 4'd2,
        SEL_PSTS = 4'd3,
        SEL_PEN  = 4'd4,
        SEL_SSTS = 4'd5,
        SEL_SEN  = 4'd6,
        SEL_BOTH = 4'd7,
        SEL_MISC = 4'd8,
        SEL_GPE  = 4'd9
    } sel_e;
endpackage

// File: rtl/gpio_evt_edge.sv
// Two-flop synchroniser plus edge detector for W asynchronous pins.
// Assumes pins are low while reset is held, so no spurious edge appears at release.
module gpio_evt_edge #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_sync,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] meta_q, sync_q, prev_q;

    // Synchronise the pins and keep last cycle's synchronised level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Compare current and previous synchronised level
    always_comb begin
        pin_sync = sync_q;
        rise     = sync_q & ~prev_q;
        fall     = ~sync_q & prev_q;
    end
endmodule

// File: rtl/gpio_evt_sticky.sv
// W-bit sticky status register, cleared by writing 1 per bit.
// A set in the same cycle as a clear wins, so no event is lost.
module gpio_evt_sticky #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    logic [W-1:0] q_r;

    // Hold bits, drop cleared ones, then apply new sets
    always_ff @(posedge clk) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= (q_r & ~clr) | set;
    end

    assign q = q_r;
endmodule

// File: rtl/gpio_event_ctrl.sv
// GPIO wake/SMI event controller: per-pin edge selection, sticky wake,
// SMI and miscellaneous status, enables, direction and data registers.
// Assumes a single clock, synchronous active-low reset, GROUPS >= 1.
module gpio_event_ctrl
    import gpio_evt_pkg::*;
#(
    parameter int GROUPS = 2,
    localparam int N  = GROUPS * GRP_PINS,
    localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int AW = GW + 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  pin_in,
    output logic [N-1:0]  pin_out,
    output logic [N-1:0]  pin_oe,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    output logic          pme_out,
    output logic          smi_out
);
    logic [GW-1:0] addr_grp;
    logic [3:0]    addr_sel;
    logic [N-1:0]  pin_s, rise, fall;
    logic [N-1:0]  pol_all, dir_all, dat_all, both_all;
    logic [N-1:0]  pme_en_all, smi_en_all;
    logic [N-1:0]  pme_sts_all, smi_sts_all, misc_sts_all;
    logic          gpe_q, pme_q, smi_q;

    assign addr_grp = reg_addr[AW-1:4];
    assign addr_sel = reg_addr[3:0];

    gpio_evt_edge #(.W(N)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .pin_sync (pin_s),
        .rise     (rise),
        .fall     (fall)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        logic       hit;
        logic [7:0] pol_q, dir_q, dat_q, both_q, pen_q, sen_q;
        logic [7:0] r, f, trig, clr_p, clr_s, clr_m;

        assign hit = reg_we && (addr_grp == GW'(g));
        assign r   = rise[g*GRP_PINS +: GRP_PINS];
        assign f   = fall[g*GRP_PINS +: GRP_PINS];

        // Configuration registers of this group
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pol_q <= '0; dir_q <= '0; dat_q <= '0;
                both_q <= '0; pen_q <= '0; sen_q <= '0;
            end else if (hit) begin
                case (addr_sel)
                    SEL_POL:  pol_q  <= reg_wdata;
                    SEL_DIR:  dir_q  <= reg_wdata;
                    SEL_DATA: dat_q  <= (reg_wdata & dir_q) | (dat_q & ~dir_q);
                    SEL_BOTH: both_q <= reg_wdata;
                    SEL_PEN:  pen_q  <= reg_wdata;
                    SEL_SEN:  sen_q  <= reg_wdata;
                    default:  ;
                endcase
            end
        end

        // Pick the qualifying edge for each pin
        always_comb begin
            trig  = (both_q & (r | f)) | (~both_q & ((~pol_q & r) | (pol_q & f)));
            clr_p = (hit && addr_sel == SEL_PSTS) ? reg_wdata : 8'h00;
            clr_s = (hit && addr_sel == SEL_SSTS) ? reg_wdata : 8'h00;
            clr_m = (hit && addr_sel == SEL_MISC) ? reg_wdata : 8'h00;
        end

        gpio_evt_sticky #(.W(GRP_PINS)) u_pme (
            .clk(clk), .rst_n(rst_n), .set(trig), .clr(clr_p),
            .q(pme_sts_all[g*GRP_PINS +: GRP_PINS])
        );
        gpio_evt_sticky #(.W(GRP_PINS)) u_smi (
            .clk(clk), .rst_n(rst_n), .set(trig), .clr(clr_s),
            .q(smi_sts_all[g*GRP_PINS +: GRP_PINS])
        );
        gpio_evt_sticky #(.W(GRP_PINS)) u_misc (
            .clk(clk), .rst_n(rst_n), .set(both_q & (r | f)), .clr(clr_m),
            .q(misc_sts_all[g*GRP_PINS +: GRP_PINS])
        );

        assign pol_all   [g*GRP_PINS +: GRP_PINS] = pol_q;
        assign dir_all   [g*GRP_PINS +: GRP_PINS] = dir_q;
        assign dat_all   [g*GRP_PINS +: GRP_PINS] = dat_q;
        assign both_all  [g*GRP_PINS +: GRP_PINS] = both_q;
        assign pme_en_all[g*GRP_PINS +: GRP_PINS] = pen_q;
        assign smi_en_all[g*GRP_PINS +: GRP_PINS] = sen_q;
    end

    // Global wake enable, reachable through any group
    always_ff @(posedge clk) begin
        if (!rst_n)                               gpe_q <= 1'b0;
        else if (reg_we && addr_sel == SEL_GPE)   gpe_q <= reg_wdata[0];
    end

    // Registered event outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pme_q <= 1'b0;
            smi_q <= 1'b0;
        end else begin
            pme_q <= gpe_q && |(pme_sts_all & pme_en_all);
            smi_q <= |(smi_sts_all & smi_en_all);
        end
    end

    // Read mux over the addressed group
    always_comb begin
        reg_rdata = 8'h00;
        for (int g = 0; g < GROUPS; g++) begin
            if (addr_grp == GW'(g)) begin
                case (addr_sel)
                    SEL_POL:  reg_rdata = pol_all[g*GRP_PINS +: GRP_PINS];
                    SEL_DIR:  reg_rdata = dir_all[g*GRP_PINS +: GRP_PINS];
                    SEL_DATA: reg_rdata = (dat_all[g*GRP_PINS +: GRP_PINS] & dir_all[g*GRP_PINS +: GRP_PINS])
                                        | (pin_s[g*GRP_PINS +: GRP_PINS] & ~dir_all[g*GRP_PINS +: GRP_PINS]);
                    SEL_PSTS: reg_rdata = pme_sts_all[g*GRP_PINS +: GRP_PINS];
                    SEL_PEN:  reg_rdata = pme_en_all[g*GRP_PINS +: GRP_PINS];
                    SEL_SSTS: reg_rdata = smi_sts_all[g*GRP_PINS +: GRP_PINS];
                    SEL_SEN:  reg_rdata = smi_en_all[g*GRP_PINS +: GRP_PINS];
                    SEL_BOTH: reg_rdata = both_all[g*GRP_PINS +: GRP_PINS];
                    SEL_MISC: reg_rdata = misc_sts_all[g*GRP_PINS +: GRP_PINS];
                    SEL_GPE:  reg_rdata = {7'b0, gpe_q};
                    default:  reg_rdata = 8'h00;
                endcase
            end
        end
    end

    assign pin_out = dat_all;
    assign pin_oe  = dir_all;
    assign pme_out = pme_q;
    assign smi_out = smi_q;
endmodule

// File: rtl/gpio_evt_chk.sv
// Temporal checks on the event controller, bound to its top module.
// Assumes the internal flattened status/enable vectors of the top.
module gpio_evt_chk #(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         reg_we,
    input logic [N-1:0] pme_sts,
    input logic [N-1:0] pme_en,
    input logic [N-1:0] smi_sts,
    input logic [N-1:0] smi_en,
    input logic [N-1:0] misc_sts,
    input logic [N-1:0] both,
    input logic         gpe,
    input logic         pme_out,
    input logic         smi_out
);
    // R5
    pme_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gpe && |(pme_sts & pme_en)) |=> pme_out);
    // R5
    pme_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gpe |=> !pme_out);
    // R6
    smi_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(smi_sts & smi_en)) |=> !smi_out);
    // R6
    smi_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(smi_sts & smi_en)) |=> smi_out);
    // R4
    pme_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> ((pme_sts & $past(pme_sts)) == $past(pme_sts)));
    // R4
    smi_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> ((smi_sts & $past(smi_sts)) == $past(smi_sts)));
    // R7
    misc_only_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((misc_sts & ~$past(misc_sts) & ~$past(both)) == '0));
endmodule

bind gpio_event_ctrl gpio_evt_chk #(.N(N)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .pme_sts  (pme_sts_all),
    .pme_en   (pme_en_all),
    .smi_sts  (smi_sts_all),
    .smi_en   (smi_en_all),
    .misc_sts (misc_sts_all),
    .both     (both_all),
    .gpe      (gpe_q),
    .pme_out  (pme_out),
    .smi_out  (smi_out)
);

// File: tb/gpio_event_ctrl_bench.sv
// Self-checking bench: directed corners plus seeded random pin activity.
module gpio_event_ctrl_bench;
    localparam int GROUPS = 2;
    localparam int N = GROUPS * 8;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pin_in = '0;
    logic [N-1:0]  pin_out, pin_oe;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          pme_out, smi_out;

    int checks = 0;
    int errors = 0;

    // model state
    logic [7:0] m_pol[GROUPS], m_both[GROUPS], m_pen[GROUPS], m_sen[GROUPS];
    logic [7:0] m_psts[GROUPS], m_ssts[GROUPS], m_msts[GROUPS];
    logic       m_gpe;

    always #5 clk = ~clk;

    gpio_event_ctrl #(.GROUPS(GROUPS)) u_gpio_event_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pme_out(pme_out), .smi_out(smi_out)
    );

    function automatic logic [AW-1:0] adr(input int g, input int s);
        return AW'((g << 4) | s);
    endfunction

    function automatic logic [7:0] edge_hit(input logic [7:0] o, input logic [7:0] n,
                                            input logic [7:0] pol, input logic [7:0] bth);
        logic [7:0] r, f;
        r = n & ~o;
        f = ~n & o;
        return (bth & (r | f)) | (~bth & ((~pol & r) | (pol & f)));
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input int g, input int s, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = adr(g, s); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int g, input int s, output logic [7:0] d);
        reg_addr = adr(g, s);
        #1;
        d = reg_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: got hang expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        process::self().srandom(32'd1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int s = 0; s < 10; s++) begin
            rd(0, s, v); chk("R1 reg reset", v, 8'h00);
        end
        chk("R1 outputs low", {6'b0, pme_out, smi_out}, 8'h00);

        // R2 rising edge sets both paths; R10 address layout; R11 group isolation
        pin_in[0] = 1'b1; settle();
        rd(0, 3, v); chk("R2 wake status", v, 8'h01);
        rd(0, 5, v); chk("R2 SMI status", v, 8'h01);
        rd(1, 3, v); chk("R11 other group untouched", v, 8'h00);

        // R4 write 0 keeps, write 1 clears, paths independent
        wr(0, 3, 8'h00); rd(0, 3, v); chk("R4 write 0 keeps", v, 8'h01);
        wr(0, 3, 8'h01); rd(0, 3, v); chk("R4 write 1 clears", v, 8'h00);
        rd(0, 5, v); chk("R4 SMI untouched by wake clear", v, 8'h01);

        // R5 wake output gating
        pin_in[0] = 1'b0; settle(); pin_in[0] = 1'b1; settle();
        wr(0, 4, 8'h01); @(negedge clk);
        chk("R5 no wake without global enable", {7'b0, pme_out}, 8'h00);
        wr(1, 9, 8'h01); @(negedge clk);
        chk("R5 wake with global enable", {7'b0, pme_out}, 8'h01);
        wr(0, 9, 8'h00); @(negedge clk);
        chk("R5 global disable drops wake", {7'b0, pme_out}, 8'h00);

        // R6 SMI independent of global enable
        chk("R6 no SMI without enable", {7'b0, smi_out}, 8'h00);
        wr(0, 6, 8'h01); @(negedge clk);
        chk("R6 SMI enabled", {7'b0, smi_out}, 8'h01);
        wr(0, 5, 8'h01); @(negedge clk);
        chk("R6 SMI drops after clear", {7'b0, smi_out}, 8'h00);
        wr(0, 3, 8'hFF);

        // R3 falling polarity
        wr(0, 0, 8'h02);
        pin_in[1] = 1'b1; settle();
        rd(0, 3, v); chk("R3 rise ignored", v, 8'h00);
        pin_in[1] = 1'b0; settle();
        rd(0, 3, v); chk("R3 fall sets", v, 8'h02);
        wr(0, 3, 8'hFF); wr(0, 5, 8'hFF);

        // R7 either-edge on group 1 pin 2
        wr(1, 7, 8'h04);
        pin_in[10] = 1'b1; pin_in[11] = 1'b1; settle();
        rd(1, 8, v); chk("R7 misc on rise", v, 8'h04);
        rd(1, 3, v); chk("R7 wake on rise", v, 8'h0C);
        wr(1, 8, 8'hFF); wr(1, 3, 8'hFF); wr(1, 5, 8'hFF);
        pin_in[10] = 1'b0; pin_in[11] = 1'b0; settle();
        rd(1, 8, v); chk("R7 misc on fall", v, 8'h04);
        rd(1, 5, v); chk("R7 SMI on fall", v, 8'h04);
        wr(1, 8, 8'hFF); wr(1, 3, 8'hFF); wr(1, 5, 8'hFF); wr(1, 7, 8'h00);

        // R4 set wins over coincident clear (pin 0 group 0, rising)
        pin_in[0] = 1'b0; settle();
        wr(0, 3, 8'hFF);
        pin_in[0] = 1'b1;
        @(negedge clk); @(negedge clk);
        reg_we = 1'b1; reg_addr = adr(0, 3); reg_wdata = 8'h01;
        @(negedge clk); reg_we = 1'b0;
        rd(0, 3, v); chk("R4 set beats clear", v, 8'h01);
        wr(0, 3, 8'hFF); wr(0, 5, 8'hFF);

        // R8 input data path
        pin_in[7:0] = 8'hA5; settle();
        rd(0, 2, v); chk("R8 input read", v, 8'hA5);
        wr(0, 2, 8'hFF);
        rd(0, 2, v); chk("R8 write ignored on read", v, 8'hA5);
        chk("R8 write ignored on pin", pin_out[7:0], 8'h00);

        // R9 output data path
        wr(0, 1, 8'hFF);
        chk("R9 output enable", pin_oe[7:0], 8'hFF);
        chk("R9 stored value before write", pin_out[7:0], 8'h00);
        wr(0, 2, 8'h3C);
        rd(0, 2, v); chk("R9 output read back", v, 8'h3C);
        chk("R9 pin driven", pin_out[7:0], 8'h3C);
        wr(0, 1, 8'h00);

        // random phase: start from clean model
        for (int g = 0; g < GROUPS; g++) begin
            wr(g, 0, 8'h00); wr(g, 7, 8'h00); wr(g, 4, 8'h00); wr(g, 6, 8'h00);
            m_pol[g] = 0; m_both[g] = 0; m_pen[g] = 0; m_sen[g] = 0;
        end
        settle();
        for (int g = 0; g < GROUPS; g++) begin
            wr(g, 3, 8'hFF); wr(g, 5, 8'hFF); wr(g, 8, 8'hFF);
            m_psts[g] = 0; m_ssts[g] = 0; m_msts[g] = 0;
        end
        m_gpe = 1'b0;

        for (int it = 0; it < 60; it++) begin
            logic [N-1:0] oldp, newp;
            int g;
            logic [7:0] d, hit;
            g = int'($urandom_range(GROUPS - 1));
            d = 8'($urandom);
            case ($urandom_range(4))
                0: begin wr(g, 0, d); m_pol[g] = d; end
                1: begin wr(g, 7, d); m_both[g] = d; end
                2: begin wr(g, 4, d); m_pen[g] = d; end
                3: begin wr(g, 6, d); m_sen[g] = d; end
                default: begin wr(g, 9, d); m_gpe = d[0]; end
            endcase
            oldp = pin_in;
            newp = oldp ^ N'($urandom);
            pin_in = newp;
            settle();
            for (int k = 0; k < GROUPS; k++) begin
                hit = edge_hit(oldp[k*8 +: 8], newp[k*8 +: 8], m_pol[k], m_both[k]);
                m_psts[k] |= hit;
                m_ssts[k] |= hit;
                m_msts[k] |= m_both[k] & (oldp[k*8 +: 8] ^ newp[k*8 +: 8]);
            end
            d = 8'($urandom);
            g = int'($urandom_range(GROUPS - 1));
            case ($urandom_range(2))
                0: begin wr(g, 3, d); m_psts[g] &= ~d; end
                1: begin wr(g, 5, d); m_ssts[g] &= ~d; end
                default: begin wr(g, 8, d); m_msts[g] &= ~d; end
            endcase
            @(negedge clk);
            begin
                logic pe, se;
                pe = 1'b0; se = 1'b0;
                for (int k = 0; k < GROUPS; k++) begin
                    rd(k, 3, v); chk("R2/R3 random wake status", v, m_psts[k]);
                    rd(k, 5, v); chk("R2/R3 random SMI status", v, m_ssts[k]);
                    rd(k, 8, v); chk("R7 random misc status", v, m_msts[k]);
                    pe |= |(m_psts[k] & m_pen[k]);
                    se |= |(m_ssts[k] & m_sen[k]);
                end
                chk("R5 random wake output", {7'b0, pme_out}, {7'b0, pe & m_gpe});
                chk("R6 random SMI output", {7'b0, smi_out}, {7'b0, se});
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule